// File: doc/BRIEF.md
# Byte-Parallel Reflected CRC-16 Engine

This block accumulates a 16-bit cyclic redundancy check over a stream of bytes, taking one byte on each clock and leaving the fully updated value in the register at the next edge. The generator is x^16 + x^15 + x^2 + 1 in its reflected, right-shifting form. Each byte is folded in least significant bit first. The register begins a message at zero, and the value it produces is used as is, with no inversion at the end.

A sender pulses the start strobe together with, or before, the first byte. It then presents bytes with the valid strobe and reads the running value from `crc_o`. The value is appended to the message low byte first. A receiver runs the whole received frame, appended bytes included, through the same engine. One clock after the last byte, the `residue_zero_o` flag reports whether the register came back to zero, which marks a good frame.

The per-byte update is a combinational XOR network, produced by unrolling eight single-bit steps. No lookup table is stored.

Top module: `crc16r_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, `crc_o` is 0x0000 and `residue_zero_o` is 1.
- R2: On a clock edge with `valid_i` high, the register becomes (c >> 8) XOR T[(c XOR d) & 0xFF]. Here c is the register value the byte is applied to and d is `data_i`. T[n] is the result of eight single-bit steps starting from n, where each step shifts right by one and XORs 0xA001 in when the bit shifted out was 1. Bit 0 of each byte is therefore consumed first.
- R3: Starting from zero, one byte gives these values: 0x01 gives 0xC0C1, 0x02 gives 0xC181, 0x80 gives 0xA001 and 0xFF gives 0x4040. The ASCII string "123456789" gives 0xBB3D.
- R4: On an edge with both `valid_i` and `start_i` low, `crc_o` does not change.
- R5: On an edge with `start_i` high and `valid_i` low, the register is cleared to zero. With both high, the byte is applied to a zero register in place of the current value.
- R6: `crc_o` is the raw register with no final inversion. Feeding a message, then the low byte of its CRC, then the high byte, returns the register to 0x0000.
- R7: `residue_zero_o` is 1 exactly when `crc_o` was 0x0000 on the previous cycle. It is therefore valid one cycle after the last byte and is 0 for a corrupted frame.
- R8: With a zero register, a 0x00 byte leaves it at zero. As a result, leading zero bytes do not change the CRC of a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a new message (clear register) |
| valid_i | input | 1 | `data_i` carries a byte this cycle |
| data_i | input | 8 | Message byte |
| crc_o | output | 16 | Current CRC register |
| residue_zero_o | output | 1 | Registered flag: register was zero last cycle |

## Verification
The hardest situation to reach from the ports is a register that returns to exactly zero partway through a stream. That only happens when the two appended bytes match the running value, which random bytes almost never produce. The bench therefore reads `crc_o` after each random message and feeds its low and high bytes back in. It then flips one bit of a replayed message to show that the flag drops. Leading-zero messages are built the same way, to expose the blind spot of a zero starting value.

// File: rtl/crc16r_pkg.sv
package crc16r_pkg;
    localparam int          CRC_W     = 16;
    localparam int          BYTE_W    = 8;
    localparam logic [15:0] POLY_REFL = 16'hA001;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // one input beat as seen by the engine
    typedef struct packed {
        logic  clr;
        logic  take;
        byte_t data;
    } beat_t;
endpackage

// File: rtl/crc16r_byte_net.sv
module crc16r_byte_net #(
    parameter int          W    = 16,
    parameter int          DW   = 8,
    parameter logic [W-1:0] POLY = 16'hA001
) (
    input  logic [W-1:0]  crc_i,
    input  logic [DW-1:0] data_i,
    output logic [W-1:0]  crc_o
);
    // stage k holds the register after k single-bit steps
    logic [W-1:0] stg [0:DW];

    assign stg[0] = crc_i ^ W'(data_i);

    for (genvar k = 0; k < DW; k++) begin : g_step
        assign stg[k+1] = stg[k][0] ? ((stg[k] >> 1) ^ POLY) : (stg[k] >> 1);
    end

    assign crc_o = stg[DW];
endmodule

// File: rtl/crc16r_state_reg.sv
module crc16r_state_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         take,
    input  logic [W-1:0] upd,
    output logic [W-1:0] crc_q,
    output logic         zero_q
);
    logic [W-1:0] crc_d;

    always_comb begin
        if (take)     crc_d = upd;
        else if (clr) crc_d = '0;
        else          crc_d = crc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q  <= '0;
            zero_q <= 1'b1;
        end else begin
            crc_q  <= crc_d;
            zero_q <= (crc_q == '0);
        end
    end
endmodule

// File: rtl/crc16r_engine.sv
module crc16r_engine
    import crc16r_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = POLY_REFL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o,
    output logic              residue_zero_o
);
    beat_t beat;
    crc_t  crc_q;
    crc_t  base;
    crc_t  upd;
    logic  zero_q;

    assign beat = '{clr: start_i, take: valid_i, data: data_i};

    // a byte arriving with start is applied to a cleared register
    assign base = beat.clr ? '0 : crc_q;

    crc16r_byte_net #(.W(CRC_W), .DW(BYTE_W), .POLY(POLY)) u_net (
        .crc_i  (base),
        .data_i (beat.data),
        .crc_o  (upd)
    );

    crc16r_state_reg #(.W(CRC_W)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .clr    (beat.clr),
        .take   (beat.take),
        .upd    (upd),
        .crc_q  (crc_q),
        .zero_q (zero_q)
    );

    assign crc_o          = crc_q;
    assign residue_zero_o = zero_q;
endmodule

// File: rtl/crc16r_engine_chk.sv
module crc16r_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        valid_i,
    input logic [7:0]  data_i,
    input logic [15:0] crc_o,
    input logic        residue_zero_o
);
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !valid_i) |=> $stable(crc_o));

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (start_i && !valid_i) |=> (crc_o == 16'h0000));

    assert_top_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (start_i && valid_i && data_i == 8'h80) |=> (crc_o == 16'hA001));

    assert_flag_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (residue_zero_o == ($past(crc_o) == 16'h0000)));

    assert_zero_stays_R8: assert property (@(posedge clk) disable iff (rst)
        (!start_i && valid_i && data_i == 8'h00 && crc_o == 16'h0000) |=> (crc_o == 16'h0000));
endmodule

bind crc16r_engine crc16r_engine_chk u_chk (.*);

// File: tb/crc16r_engine_tb.sv
module crc16r_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [7:0]  data_i = 8'h00;
    logic [15:0] crc_o;
    logic        residue_zero_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [15:0] tbl [0:255];

    always #2 clk = ~clk;

    crc16r_engine u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i),
        .data_i(data_i), .crc_o(crc_o), .residue_zero_o(residue_zero_o)
    );

    function automatic logic [15:0] model(logic [15:0] c, logic [7:0] d);
        logic [7:0] idx;
        idx = c[7:0] ^ d;
        return (c >> 8) ^ tbl[idx];
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle from a negedge; returns on the next negedge
    task automatic cyc(bit st, bit v, logic [7:0] d);
        start_i = st; valid_i = v; data_i = d;
        @(negedge clk);
        start_i = 0; valid_i = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] m, saved;
        logic [7:0]  msg [0:15];
        string       ascii;
        int          seed;

        for (int n = 0; n < 256; n++) begin
            logic [15:0] t;
            t = 16'(n);
            for (int b = 0; b < 8; b++) t = t[0] ? ((t >> 1) ^ 16'hA001) : (t >> 1);
            tbl[n] = t;
        end
        seed = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        chk("R1 crc during reset", crc_o, 16'h0000);
        rst = 0;
        @(negedge clk);
        chk("R1 crc after reset", crc_o, 16'h0000);
        chk("R1 flag after reset", 16'(residue_zero_o), 16'h0001);

        // R3 single-byte points
        cyc(1, 1, 8'h01); chk("R3 T[01]", crc_o, 16'hC0C1);
        cyc(1, 1, 8'h02); chk("R3 T[02]", crc_o, 16'hC181);
        cyc(1, 1, 8'h80); chk("R3 T[80]", crc_o, 16'hA001);
        cyc(1, 1, 8'hFF); chk("R3 T[FF]", crc_o, 16'h4040);

        // R3 ASCII check string, then R6 append and R7 flag
        ascii = "123456789";
        for (int i = 0; i < ascii.len(); i++) cyc(i == 0, 1, ascii[i]);
        chk("R3 check string", crc_o, 16'hBB3D);
        saved = crc_o;
        cyc(0, 0, 8'h5A);
        chk("R4 hold without valid", crc_o, saved);
        chk("R7 flag low on nonzero", 16'(residue_zero_o), 16'h0000);
        cyc(0, 1, saved[7:0]);
        cyc(0, 1, saved[15:8]);
        chk("R6 residue after append", crc_o, 16'h0000);
        cyc(0, 0, 8'h00);
        chk("R7 flag after good frame", 16'(residue_zero_o), 16'h0001);

        // R5 clear alone
        cyc(1, 1, 8'h37);
        cyc(1, 0, 8'h00);
        chk("R5 start clears", crc_o, 16'h0000);

        // random frames with gaps
        for (int f = 0; f < 40; f++) begin
            int len;
            len = 1 + ($urandom % 16);
            m = 16'h0000;
            for (int i = 0; i < len; i++) begin
                msg[i] = 8'($urandom);
                m = model(m, msg[i]);
                cyc(i == 0, 1, msg[i]);
                chk("R2 random byte", crc_o, m);
                if (($urandom % 4) == 0) begin
                    cyc(0, 0, 8'($urandom));
                    chk("R4 random gap", crc_o, m);
                end
            end
            saved = crc_o;
            cyc(0, 1, saved[7:0]);
            cyc(0, 1, saved[15:8]);
            chk("R6 random residue", crc_o, 16'h0000);
            cyc(0, 0, 8'h00);
            chk("R7 random good flag", 16'(residue_zero_o), 16'h0001);

            // replay with one bit flipped
            begin
                int pos;
                pos = $urandom % len;
                for (int i = 0; i < len; i++)
                    cyc(i == 0, 1, (i == pos) ? (msg[i] ^ (8'h01 << ($urandom % 8))) : msg[i]);
                cyc(0, 1, saved[7:0]);
                cyc(0, 1, saved[15:8]);
                cyc(0, 0, 8'h00);
                chk("R7 corrupted flag", 16'(residue_zero_o), 16'h0000);
            end

            // R8 leading zeros blind spot
            begin
                int nz;
                nz = 1 + ($urandom % 5);
                cyc(1, 0, 8'h00);
                for (int z = 0; z < nz; z++) cyc(0, 1, 8'h00);
                chk("R8 zeros keep zero", crc_o, 16'h0000);
                for (int i = 0; i < len; i++) cyc(0, 1, msg[i]);
                chk("R8 leading zeros unseen", crc_o, saved);
            end
        end

        // R5 start with byte discards a nonzero register
        cyc(1, 1, 8'hC3);
        cyc(1, 1, 8'h80);
        chk("R5 start+valid uses zero", crc_o, 16'hA001);

        finish_run();
    end
endmodule